// File: doc/BRIEF.md
# DMA Setup Register Bank

This block holds the values a DMA engine needs before it starts a transfer: a 22-bit word address, a 14-bit transfer count, a direction flag and an enable flag. The host programs them through a simple register-write port. The address register is unusual. Its new value is taken from bits of the bus address used for the write, not from the data bus. Address bit 14 of that write picks which half of the DMA address is replaced.

A write to the count register stores the count together with the direction and enable flags. The stored count then advances by one straight away. Reading the count returns the 14-bit value with its two top bits forced high. The count register takes only 16-bit accesses. Any other access size raises a one-cycle flag, but the access still takes effect. While a transfer runs, the engine pulses a strobe once per word moved. Each pulse moves the address on by two bytes and adds one to the count.

There is no streamed data at this block's edge. Every pin is a plain control or status signal with no back-pressure.

Top module: `dma_setup_regs`

## Requirements
- R1: After reset the DMA address, count, direction flag and enable flag are all zero, and the size flag is low.
- R2: An address-register write with `wr_addr[14]` high loads DMA address bits [21:9] from `wr_addr[13:1]`. DMA address bits [8:1] keep their value.
- R3: An address-register write with `wr_addr[14]` low loads DMA address bits [8:1] from `wr_addr[8:1]`. DMA address bits [21:9] keep their value, and DMA address bit 0 is always zero.
- R4: A count-register write stores `wr_data[15]` as the enable flag and `wr_data[14]` as the direction flag (1 = read). It then stores `wr_data[13:0]` plus one, modulo 2^14, as the count.
- R5: While `cnt_rd` is high, `rd_data` equals {2'b11, count} in the same cycle. While `cnt_rd` is low, `rd_data` is zero.
- R6: `size_err` is high in the cycle after a count write or count read whose size code is not 01. The size codes are 00 byte, 01 word, 10 long and 11 reserved. A mis-sized write still updates the count register.
- R7: Each cycle with `xfer_stb` high adds 2 to the DMA address, modulo 2^22, and adds 1 to the count, modulo 2^14.
- R8: When a host write and `xfer_stb` occur in the same cycle, the host value wins in the register being written. The other register still advances by its engine step.
- R9: The direction and enable flags change only on a count-register write. Address writes and transfer strobes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_addr | input | 14 | Bus address bits [14:1] of the current register write |
| wr_data | input | 16 | Write data for the count register |
| wr_size | input | 2 | Size code of the write (00 byte, 01 word, 10 long) |
| adr_wr | input | 1 | Write strobe, address register |
| cnt_wr | input | 1 | Write strobe, count register |
| cnt_rd | input | 1 | Read strobe, count register |
| rd_size | input | 2 | Size code of the read |
| rd_data | output | 16 | Count readback |
| size_err | output | 1 | Pulse: count register accessed with a size other than word |
| xfer_stb | input | 1 | Engine strobe, one per word transferred |
| dma_addr | output | 22 | Current DMA byte address |
| dma_count | output | 14 | Current transfer count |
| dma_dir | output | 1 | Direction flag (1 = read from memory) |
| dma_en | output | 1 | DMA enable flag |

## Verification
The hardest case to reach from the ports is a host write and an engine strobe landing in the same cycle. In that case one register must take the host value while the other still advances. The bench drives that collision on purpose, once for each register, and checks both registers afterwards. The wrap boundaries are also hard to reach by counting up, because that would take millions of strobes. The bench instead loads the address halves and the count directly with all-ones values, then strobes across the boundary.

// File: rtl/dma_setup_pkg.sv
package dma_setup_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int ADDR_W  = 22,
  parameter int LO_BITS = 8,
  parameter int SEL_BIT = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_BIT:1]    wr_addr,
  input  logic                adr_wr,
  input  logic                xfer_stb,
  output logic [ADDR_W-1:0]   dma_addr
);
  localparam int WORD_W = ADDR_W - 1;
  localparam int HI_W   = WORD_W - LO_BITS;
  localparam logic [WORD_W-1:0] WORD_ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (adr_wr) begin
      if (wr_addr[SEL_BIT]) word_q[WORD_W-1:LO_BITS] <= wr_addr[HI_W:1];
      else                  word_q[LO_BITS-1:0]      <= wr_addr[LO_BITS:1];
    end else if (xfer_stb) begin
      word_q <= word_q + WORD_ONE;
    end
  end

  assign dma_addr = {word_q, 1'b0};

  // R2
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_wr && wr_addr[SEL_BIT] |=>
      dma_addr[ADDR_W-1:LO_BITS+1] == $past(wr_addr[HI_W:1]) &&
      dma_addr[LO_BITS:1] == $past(dma_addr[LO_BITS:1]));

  // R3
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_wr && !wr_addr[SEL_BIT] |=>
      dma_addr[LO_BITS:1] == $past(wr_addr[LO_BITS:1]) &&
      dma_addr[ADDR_W-1:LO_BITS+1] == $past(dma_addr[ADDR_W-1:LO_BITS+1]));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb && !adr_wr |=> dma_addr == $past(dma_addr) + ADDR_W'(2));
endmodule

// File: rtl/dma_count_reg.sv
module dma_count_reg
  import dma_setup_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W+1:0]  wr_data,
  input  logic [1:0]        wr_size,
  input  logic              cnt_wr,
  input  logic              cnt_rd,
  input  logic [1:0]        rd_size,
  input  logic              xfer_stb,
  output logic [CNT_W+1:0]  rd_data,
  output logic              size_err,
  output logic [CNT_W-1:0]  dma_count,
  output logic              dma_dir,
  output logic              dma_en
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic bad_wr, bad_rd;
  assign bad_wr = cnt_wr && (wr_size != SZ_WORD);
  assign bad_rd = cnt_rd && (rd_size != SZ_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_count <= '0;
      dma_dir   <= 1'b0;
      dma_en    <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      size_err <= bad_wr || bad_rd;
      if (cnt_wr) begin
        dma_count <= wr_data[CNT_W-1:0] + CNT_ONE;
        dma_dir   <= wr_data[CNT_W];
        dma_en    <= wr_data[CNT_W+1];
      end else if (xfer_stb) begin
        dma_count <= dma_count + CNT_ONE;
      end
    end
  end

  assign rd_data = cnt_rd ? {2'b11, dma_count} : '0;

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> dma_count == $past(wr_data[CNT_W-1:0]) + CNT_ONE &&
               dma_en == $past(wr_data[CNT_W+1]));

  // R6
  size_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && wr_size != SZ_WORD) || (cnt_rd && rd_size != SZ_WORD) |=> size_err);

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> $stable(dma_en) && $stable(dma_dir));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb && !cnt_wr |=> dma_count == $past(dma_count) + CNT_ONE);
endmodule

// File: rtl/dma_setup_regs.sv
module dma_setup_regs #(
  parameter int ADDR_W  = 22,
  parameter int LO_BITS = 8,
  parameter int SEL_BIT = 14,
  parameter int CNT_W   = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_BIT:1]    wr_addr,
  input  logic [CNT_W+1:0]    wr_data,
  input  logic [1:0]          wr_size,
  input  logic                adr_wr,
  input  logic                cnt_wr,
  input  logic                cnt_rd,
  input  logic [1:0]          rd_size,
  output logic [CNT_W+1:0]    rd_data,
  output logic                size_err,
  input  logic                xfer_stb,
  output logic [ADDR_W-1:0]   dma_addr,
  output logic [CNT_W-1:0]    dma_count,
  output logic                dma_dir,
  output logic                dma_en
);
  dma_addr_reg #(
    .ADDR_W (ADDR_W),
    .LO_BITS(LO_BITS),
    .SEL_BIT(SEL_BIT)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_addr (wr_addr),
    .adr_wr  (adr_wr),
    .xfer_stb(xfer_stb),
    .dma_addr(dma_addr)
  );

  dma_count_reg #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_data  (wr_data),
    .wr_size  (wr_size),
    .cnt_wr   (cnt_wr),
    .cnt_rd   (cnt_rd),
    .rd_size  (rd_size),
    .xfer_stb (xfer_stb),
    .rd_data  (rd_data),
    .size_err (size_err),
    .dma_count(dma_count),
    .dma_dir  (dma_dir),
    .dma_en   (dma_en)
  );
endmodule

// File: tb/test_dma_setup_regs.sv
`timescale 1ns/1ps
module test_dma_setup_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:1] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_size = 2'b01;
  logic        adr_wr = 1'b0, cnt_wr = 1'b0, cnt_rd = 1'b0, xfer_stb = 1'b0;
  logic [1:0]  rd_size = 2'b01;
  logic [15:0] rd_data;
  logic        size_err;
  logic [21:0] dma_addr;
  logic [13:0] dma_count;
  logic        dma_dir, dma_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic [21:0] e_addr;
  logic [13:0] e_cnt;
  logic        e_dir, e_en;

  always #2.5 clk = ~clk;

  dma_setup_regs i_dma_setup_regs (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_size(wr_size), .adr_wr(adr_wr), .cnt_wr(cnt_wr), .cnt_rd(cnt_rd),
    .rd_size(rd_size), .rd_data(rd_data), .size_err(size_err),
    .xfer_stb(xfer_stb), .dma_addr(dma_addr), .dma_count(dma_count),
    .dma_dir(dma_dir), .dma_en(dma_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    adr_wr = 1'b0; cnt_wr = 1'b0; cnt_rd = 1'b0; xfer_stb = 1'b0;
    wr_size = 2'b01; rd_size = 2'b01;
  endtask

  task automatic check_all(input string tag);
    chk(tag, {10'd0, dma_addr}, {10'd0, e_addr});
    chk(tag, {18'd0, dma_count}, {18'd0, e_cnt});
    chk(tag, {30'd0, dma_dir, dma_en}, {30'd0, e_dir, e_en});
  endtask

  task automatic load_addr(input logic [14:1] a);
    wr_addr = a; adr_wr = 1'b1;
    tick(); idle();
    if (a[14]) e_addr[21:9] = a[13:1];
    else       e_addr[8:1]  = a[8:1];
  endtask

  task automatic load_cnt(input logic [15:0] d);
    wr_data = d; cnt_wr = 1'b1;
    tick(); idle();
    e_cnt = d[13:0] + 14'd1; e_dir = d[14]; e_en = d[15];
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    e_addr = '0; e_cnt = '0; e_dir = 1'b0; e_en = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check_all("R1");
    chk("R1 size_err", {31'd0, size_err}, 32'd0);

    // R4, R5: every count value, flags from low bits of the index
    for (int i = 0; i < 16384; i++) begin
      logic [15:0] d;
      d = {i[3], i[5], i[13:0]};
      load_cnt(d);
      check_all("R4");
      cnt_rd = 1'b1; #1;
      chk("R5", {16'd0, rd_data}, {16'd0, 2'b11, e_cnt});
      tick(); idle();
      chk("R6 word ok", {31'd0, size_err}, 32'd0);
    end
    #1;
    chk("R5 idle", {16'd0, rd_data}, 32'd0);

    // R2: every high half; low half kept
    load_addr(14'h00A5);
    for (int h = 0; h < 8192; h++) begin
      logic [12:0] hv;
      hv = h[12:0];
      load_addr({1'b1, hv});
      check_all("R2");
    end
    // R3: every low half; high half kept
    for (int l = 0; l < 256; l++) begin
      logic [7:0] lv;
      lv = l[7:0];
      load_addr({1'b0, 5'h15, lv});
      check_all("R3");
    end

    // R7, R9: engine strobes crossing the wrap points
    load_addr({1'b1, 13'h1FFF});
    load_addr({1'b0, 5'h00, 8'hFF});
    load_cnt(16'hBFFC);
    for (int k = 0; k < 6; k++) begin
      xfer_stb = 1'b1;
      tick(); idle();
      e_addr = e_addr + 22'd2; e_cnt = e_cnt + 14'd1;
      check_all("R7");
    end

    // R8: host address write collides with strobe
    xfer_stb = 1'b1; adr_wr = 1'b1; wr_addr = {1'b0, 5'h00, 8'h40};
    tick(); idle();
    e_addr[8:1] = 8'h40; e_cnt = e_cnt + 14'd1;
    check_all("R8 addr");
    // R8: host count write collides with strobe
    xfer_stb = 1'b1; cnt_wr = 1'b1; wr_data = 16'h4123;
    tick(); idle();
    e_addr = e_addr + 22'd2; e_cnt = 14'h0124; e_dir = 1'b1; e_en = 1'b0;
    check_all("R8 count");

    // R6: size codes on write and read
    for (int s = 0; s < 4; s++) begin
      logic [1:0] sz;
      sz = s[1:0];
      wr_size = sz; cnt_wr = 1'b1; wr_data = 16'h8010;
      tick(); idle();
      e_cnt = 14'h0011; e_dir = 1'b0; e_en = 1'b1;
      chk("R6 wr", {31'd0, size_err}, {31'd0, sz != 2'b01});
      check_all("R6 wr stored");
      rd_size = sz; cnt_rd = 1'b1;
      tick(); idle();
      chk("R6 rd", {31'd0, size_err}, {31'd0, sz != 2'b01});
      tick();
      chk("R6 clear", {31'd0, size_err}, 32'd0);
    end

    // R1: reset again clears everything
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    e_addr = '0; e_cnt = '0; e_dir = 1'b0; e_en = 1'b0;
    check_all("R1 re-reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule